// File: doc/BRIEF.md
# Stereo Receive Interrupt Controller

This block keeps the two receive-side "word waiting" flags of a stereo serial audio receiver, one for the left channel and one for the right, and turns them into one interrupt request with a vector address. Up to `NUM_LANES` parallel data lanes share the controller. Each flag therefore stands for all enabled lanes together. The receive shift logic sends a one-cycle completion strobe for each channel. The bus side sends read strobes for the status register and for each lane's data register, plus a control write that loads the interrupt-enable bit and the vector-location bit together.

A single flag is cleared once every enabled lane's data register has been read. When both flags are up at once, a word has been lost (overrun). That state is cleared only by a status read followed by the data reads. A small sequencer handles this with three states:

- `SEQ_IDLE`: not armed.
- `SEQ_ARMED`: a status read has been seen.
- `SEQ_DRAIN`: armed, and some of the data reads have arrived.

Its transitions are:

- ARM: IDLE to ARMED on a status read.
- PARTIAL: ARMED to DRAIN on a data read that does not finish the set of lanes.
- FINISH: ARMED or DRAIN to IDLE when the reads finish.
- ABORT: any state to IDLE on a control write or a software reset.

Clearing the enable bit takes effect on the request one cycle late. A software reset clears both control bits, and the request drops at once.

Top module: `srx_irq_ctrl`

## Requirements
- R1: A completion strobe sets its channel's flag on the next edge. If a strobe and a clearing read land in the same cycle, the flag stays set.
- R2: While the enable bit is 0, `irq` stays low and the flags still set and clear as usual, so software can poll them.
- R3: With enable 1, left flag 1 and right flag 0, `irq` is 1 and `irq_vec` is the base plus 0.
- R4: With enable 1, left flag 0 and right flag 1, `irq` is 1 and `irq_vec` is the base plus 2.
- R5: With enable 1 and both flags 1 (overrun), `irq` is 1 and `irq_vec` is the base plus 4.
- R6: The base is 0x16 when the location bit is 0 and 0x46 when it is 1. The vectors are therefore 0x16/0x18/0x1A or 0x46/0x48/0x4A.
- R7: A lone flag clears only when every lane with its `lane_en` bit at 1 has had its `data_rd` bit pulsed. Reads may arrive in separate cycles. Lanes with `lane_en` at 0 are not needed.
- R8: When both flags are set, data reads alone leave both set. A status read followed by reads of all enabled lanes clears both.
- R9: A control write between the status read and the data reads cancels the armed state, so the data reads that follow leave both flags set.
- R10: After a control write that clears enable, `irq` still reflects the flags for one more cycle, then drops.
- R11: Hardware reset clears both flags, `irq` and `irq_vec`. A software reset pulse clears the enable and location bits, and `irq` is 0 after that edge while the flags are kept.
- R12: `irq_vec` is 0 whenever `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Software reset pulse |
| lane_en | input | NUM_LANES | Enabled receive lanes |
| left_done | input | 1 | Left word received strobe |
| right_done | input | 1 | Right word received strobe |
| stat_rd | input | 1 | Status register read strobe |
| data_rd | input | NUM_LANES | Per-lane data register read strobes |
| ctl_wr | input | 1 | Control write strobe |
| ctl_ie | input | 1 | Interrupt-enable value for a control write |
| ctl_loc | input | 1 | Vector-location value for a control write |
| left_full | output | 1 | Left flag |
| right_full | output | 1 | Right flag |
| irq | output | 1 | Interrupt request |
| irq_vec | output | VEC_W | Vector address of the current request |

## Verification
The assertions assume that every strobe input is sampled cleanly at the rising edge. They also assume that `ctl_ie` and `ctl_loc` matter only in a cycle with `ctl_wr`, and that `lane_en` does not change while a set of data reads is being collected. The stimulus changes inputs one nanosecond after each edge and returns every strobe to 0 after one cycle. It changes `lane_en` only when no read set is open. In this way the lane-collection and clear-sequence properties see only the input patterns they were written for.

// File: rtl/srx_irq_pkg.sv
package srx_irq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ARMED = 2'd1,
        SEQ_DRAIN = 2'd2
    } seq_state_t;

    localparam int CH_LEFT  = 0;
    localparam int CH_RIGHT = 1;
    localparam int NUM_CH   = 2;

endpackage

// File: rtl/srx_flag_cell.sv
module srx_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic full_o
);

    logic full_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_q <= 1'b0;
        end else if (set_i) begin
            full_q <= 1'b1;
        end else if (clr_i) begin
            full_q <= 1'b0;
        end
    end

    assign full_o = full_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> full_o);                                  // R1
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !full_o);                     // R7

endmodule

// File: rtl/srx_read_collect.sv
module srx_read_collect #(
    parameter int NUM_LANES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 soft_rst,
    input  logic [NUM_LANES-1:0] lane_en,
    input  logic [NUM_LANES-1:0] data_rd,
    output logic                 rd_done
);

    logic [NUM_LANES-1:0] seen_q;
    logic [NUM_LANES-1:0] hit;

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        assign hit[i] = seen_q[i] | data_rd[i] | ~lane_en[i];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                seen_q[i] <= 1'b0;
            end else if (soft_rst || rd_done) begin
                seen_q[i] <= 1'b0;
            end else if (data_rd[i] && lane_en[i]) begin
                seen_q[i] <= 1'b1;
            end
        end
    end

    assign rd_done = (&hit) & (|lane_en);

    AST_DONE_NEEDS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> (|lane_en));                            // R7
    AST_SEEN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> (seen_q == '0));                        // R7

endmodule

// File: rtl/srx_clear_seq.sv
module srx_clear_seq
    import srx_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic ctl_wr,
    input  logic stat_rd,
    input  logic any_rd,
    input  logic rd_done,
    output logic armed
);

    seq_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (soft_rst || ctl_wr) begin
            state_d = SEQ_IDLE;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (stat_rd) state_d = SEQ_ARMED;
                end
                SEQ_ARMED: begin
                    if (rd_done)     state_d = SEQ_IDLE;
                    else if (any_rd) state_d = SEQ_DRAIN;
                end
                SEQ_DRAIN: begin
                    if (rd_done) state_d = SEQ_IDLE;
                end
                default: state_d = SEQ_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            SEQ_ARMED, SEQ_DRAIN: armed = 1'b1;
            default:              armed = 1'b0;
        endcase
    end

    AST_ABORT_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr || soft_rst) |=> !armed);                   // R9
    AST_STATUS_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !ctl_wr && !soft_rst && !rd_done) |=> armed);  // R8
    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != 2'd3);                                   // R8

endmodule

// File: rtl/srx_irq_decode.sv
module srx_irq_decode #(
    parameter int               VEC_W    = 8,
    parameter logic [VEC_W-1:0] VEC_LO   = 8'h16,
    parameter logic [VEC_W-1:0] VEC_HI   = 8'h46,
    parameter int               VEC_STEP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             ctl_wr,
    input  logic             ctl_ie,
    input  logic             ctl_loc,
    input  logic             lf,
    input  logic             rf,
    output logic             irq,
    output logic [VEC_W-1:0] irq_vec
);

    logic             ie_q;
    logic             ie_late_q;
    logic             loc_q;
    logic             ie_eff;
    logic [VEC_W-1:0] base;
    logic [VEC_W-1:0] off;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q      <= 1'b0;
            ie_late_q <= 1'b0;
            loc_q     <= 1'b0;
        end else if (soft_rst) begin
            ie_q      <= 1'b0;
            ie_late_q <= 1'b0;
            loc_q     <= 1'b0;
        end else begin
            ie_late_q <= ie_q;
            if (ctl_wr) begin
                ie_q  <= ctl_ie;
                loc_q <= ctl_loc;
            end
        end
    end

    assign ie_eff = ie_q | ie_late_q;
    assign irq    = ie_eff & (lf | rf);
    assign base   = loc_q ? VEC_HI : VEC_LO;

    always_comb begin
        if (lf && rf)  off = VEC_W'(2 * VEC_STEP);
        else if (rf)   off = VEC_W'(VEC_STEP);
        else           off = '0;
    end

    assign irq_vec = irq ? (base + off) : '0;

    AST_LATE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_q && ctl_wr && !ctl_ie && !soft_rst) |=> (irq == (lf || rf)));  // R10
    AST_SOFT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !irq);                                 // R11
    AST_VEC_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_vec != '0));                           // R12
    AST_REQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (lf || rf));                                // R2

endmodule

// File: rtl/srx_irq_ctrl.sv
module srx_irq_ctrl
    import srx_irq_pkg::*;
#(
    parameter int               NUM_LANES = 2,
    parameter int               VEC_W     = 8,
    parameter logic [VEC_W-1:0] VEC_LO    = 8'h16,
    parameter logic [VEC_W-1:0] VEC_HI    = 8'h46,
    parameter int               VEC_STEP  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 soft_rst,
    input  logic [NUM_LANES-1:0] lane_en,
    input  logic                 left_done,
    input  logic                 right_done,
    input  logic                 stat_rd,
    input  logic [NUM_LANES-1:0] data_rd,
    input  logic                 ctl_wr,
    input  logic                 ctl_ie,
    input  logic                 ctl_loc,
    output logic                 left_full,
    output logic                 right_full,
    output logic                 irq,
    output logic [VEC_W-1:0]     irq_vec
);

    logic [NUM_CH-1:0] full;
    logic [NUM_CH-1:0] set_ch;
    logic [NUM_CH-1:0] clr_ch;
    logic              rd_done;
    logic              armed;
    logic              both;

    assign set_ch[CH_LEFT]  = left_done;
    assign set_ch[CH_RIGHT] = right_done;
    assign both             = full[CH_LEFT] & full[CH_RIGHT];

    assign clr_ch[CH_LEFT]  = rd_done &
        ((full[CH_LEFT] & ~full[CH_RIGHT]) | (both & armed));
    assign clr_ch[CH_RIGHT] = rd_done &
        ((full[CH_RIGHT] & ~full[CH_LEFT]) | (both & armed));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        srx_flag_cell u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_ch[c]),
            .clr_i  (clr_ch[c]),
            .full_o (full[c])
        );
    end

    srx_read_collect #(.NUM_LANES(NUM_LANES)) u_collect (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .lane_en  (lane_en),
        .data_rd  (data_rd),
        .rd_done  (rd_done)
    );

    srx_clear_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .ctl_wr   (ctl_wr),
        .stat_rd  (stat_rd),
        .any_rd   (|(data_rd & lane_en)),
        .rd_done  (rd_done),
        .armed    (armed)
    );

    srx_irq_decode #(
        .VEC_W    (VEC_W),
        .VEC_LO   (VEC_LO),
        .VEC_HI   (VEC_HI),
        .VEC_STEP (VEC_STEP)
    ) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .ctl_wr   (ctl_wr),
        .ctl_ie   (ctl_ie),
        .ctl_loc  (ctl_loc),
        .lf       (full[CH_LEFT]),
        .rf       (full[CH_RIGHT]),
        .irq      (irq),
        .irq_vec  (irq_vec)
    );

    assign left_full  = full[CH_LEFT];
    assign right_full = full[CH_RIGHT];

    AST_OVR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (left_full && right_full && !armed) |=> (left_full && right_full));  // R8
    AST_NO_SILENT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (left_full && !rd_done) |=> left_full);             // R7

endmodule

// File: tb/sim_srx_irq_ctrl.sv
`timescale 1ns/1ps
module sim_srx_irq_ctrl;

    localparam int NL = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          soft_rst = 1'b0;
    logic [NL-1:0] lane_en = '1;
    logic          left_done = 1'b0;
    logic          right_done = 1'b0;
    logic          stat_rd = 1'b0;
    logic [NL-1:0] data_rd = '0;
    logic          ctl_wr = 1'b0;
    logic          ctl_ie = 1'b0;
    logic          ctl_loc = 1'b0;
    logic          left_full;
    logic          right_full;
    logic          irq;
    logic [7:0]    irq_vec;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    srx_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .lane_en(lane_en),
        .left_done(left_done), .right_done(right_done), .stat_rd(stat_rd),
        .data_rd(data_rd), .ctl_wr(ctl_wr), .ctl_ie(ctl_ie), .ctl_loc(ctl_loc),
        .left_full(left_full), .right_full(right_full), .irq(irq), .irq_vec(irq_vec)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic strobe(input logic l, input logic r);
        left_done = l; right_done = r; tick(); left_done = 0; right_done = 0;
    endtask
    task automatic wr_ctl(input logic ie, input logic loc);
        ctl_wr = 1; ctl_ie = ie; ctl_loc = loc; tick(); ctl_wr = 0;
    endtask
    task automatic rd_stat();
        stat_rd = 1; tick(); stat_rd = 0;
    endtask
    task automatic rd_data(input logic [NL-1:0] m);
        data_rd = m; tick(); data_rd = '0;
    endtask

    task automatic t_reset();
        chk("R11 reset left", left_full, 0);
        chk("R11 reset right", right_full, 0);
        chk("R11 reset irq", irq, 0);
        chk("R12 reset vec", irq_vec, 0);
    endtask

    task automatic t_poll();
        strobe(1, 0);
        chk("R2 poll flag set", left_full, 1);
        chk("R2 poll no irq", irq, 0);
        rd_data(2'b11);
        chk("R2 poll flag cleared", left_full, 0);
    endtask

    task automatic t_left();
        wr_ctl(1, 0);
        strobe(1, 0);
        chk("R3 left irq", irq, 1);
        chk("R3 R6 left vec", irq_vec, 8'h16);
        rd_data(2'b01);
        chk("R7 partial keeps flag", left_full, 1);
        rd_data(2'b10);
        chk("R7 all lanes clear", left_full, 0);
        chk("R12 vec idle", irq_vec, 0);
    endtask

    task automatic t_right_hi();
        wr_ctl(1, 1);
        lane_en = 2'b01;
        strobe(0, 1);
        chk("R4 right irq", irq, 1);
        chk("R4 R6 right vec hi", irq_vec, 8'h48);
        rd_data(2'b01);
        chk("R7 disabled lane skipped", right_full, 0);
        lane_en = 2'b11;
    endtask

    task automatic t_overrun();
        wr_ctl(1, 0);
        strobe(1, 1);
        chk("R5 ovr vec", irq_vec, 8'h1A);
        rd_data(2'b11);
        chk("R8 no status left", left_full, 1);
        chk("R8 no status right", right_full, 1);
        rd_stat();
        rd_data(2'b01);
        chk("R8 partial keeps both", {left_full, right_full}, 2'b11);
        rd_data(2'b10);
        chk("R8 sequence clears", {left_full, right_full}, 2'b00);
    endtask

    task automatic t_abort();
        strobe(1, 1);
        rd_stat();
        wr_ctl(1, 1);
        chk("R5 R6 ovr vec hi", irq_vec, 8'h4A);
        rd_data(2'b11);
        chk("R9 arm dropped", {left_full, right_full}, 2'b11);
        rd_stat();
        rd_data(2'b11);
        chk("R9 rearm clears", {left_full, right_full}, 2'b00);
    endtask

    task automatic t_setwins();
        strobe(1, 0);
        left_done = 1; data_rd = 2'b11; tick(); left_done = 0; data_rd = '0;
        chk("R1 set wins", left_full, 1);
        rd_data(2'b11);
        chk("R1 later clear", left_full, 0);
    endtask

    task automatic t_late_mask();
        wr_ctl(1, 0);
        strobe(1, 0);
        wr_ctl(0, 0);
        chk("R10 one more cycle", irq, 1);
        tick();
        chk("R10 masked", irq, 0);
        chk("R2 flag kept", left_full, 1);
        rd_data(2'b11);
    endtask

    task automatic t_soft();
        wr_ctl(1, 1);
        strobe(0, 1);
        chk("R11 pre soft irq", irq, 1);
        soft_rst = 1; tick(); soft_rst = 0;
        chk("R11 soft irq", irq, 0);
        chk("R11 soft flag kept", right_full, 1);
        wr_ctl(1, 0);
        strobe(1, 0);
        rst_n = 0; #2;
        chk("R11 hw left", left_full, 0);
        chk("R11 hw right", right_full, 0);
        chk("R11 hw irq", irq, 0);
        tick(); rst_n = 1; tick();
    endtask

    initial begin
        #200000;
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(); tick();
        rst_n = 1;
        tick();
        t_reset();
        t_poll();
        t_left();
        t_right_hi();
        t_overrun();
        t_abort();
        t_setwins();
        t_late_mask();
        t_soft();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule